// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a watchdog that software keeps alive by kicking it inside a permitted interval. When it is enabled, it runs two timed phases one after the other. The first is a closed phase, in which a kick is forbidden. The second is an open phase, in which a kick is required. A kick in the open phase starts the sequence again from a fresh closed phase. A kick that comes too early, or no kick before the open phase runs out, raises a reset output. That output stays high until the system reset.

The host reaches the block through a simple synchronous register bus with a write strobe, a read strobe, a 5-bit byte address and 32-bit data. Writes to the control register are guarded by an unlock register. Software writes a 1 to the unlock register, and the next control write then takes effect. Both phase lengths live in their own registers. They are captured each time a closed phase begins, so software can reprogram them at any time without disturbing the phase that is already running.

Top module: `window_watchdog`

## Requirements
- R1: After the system reset (`rst` high, synchronous), every register reads 0 and `fault_rst` is 0.
- R2: The register map is as follows. Address 0x00 is unlock (bit 0). Address 0x04 is control. Address 0x0C is the closed-phase length and address 0x10 is the open-phase length; both are full 32-bit read/write registers. Address 0x08 and every other address read 0, and writes to them have no effect. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R3: A control write takes effect only if the unlock bit was set by an earlier write of 1 to address 0x00. Any control write clears the unlock bit. A control write without the unlock bit set is ignored.
- R4: In the control register, bit 0 is the enable and bit 8 is the kick. Enabling the block starts a closed phase of C cycles, followed by an open phase of O cycles. C and O are the values of the two length registers, and a value of 0 counts as 1. Measured from the cycle d of the enabling write, a kick write at d = 1..C lands in the closed phase and one at d = C+1..C+O lands in the open phase.
- R5: A kick is a control write with bits 0 and 8 both set. A kick in the open phase restarts the sequence from a new closed phase, with no fault. Bit 8 reads 0 from the second cycle after the kick write.
- R6: A kick in the closed phase raises `fault_rst` on the next cycle.
- R7: If no kick arrives by the end of the open phase, `fault_rst` rises C+O+1 cycles after the enabling write.
- R8: `fault_rst` is sticky. Control bit 16 reads 1 while it is set. Clearing the enable does not clear it; only `rst` does.
- R9: The phase lengths are captured when a closed phase begins. Writes to the length registers during a run apply from the next closed phase.
- R10: Clearing the enable returns the block to idle, and no fault follows. A write with bit 8 set while the block is disabled is not a kick, even if the same write sets the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| fault_rst | output | 1 | Sticky window-violation reset output |

## Verification
Any phase boundary that is off by one moves the edge between a fatal kick and an accepted kick. The bench therefore places single kicks on the last closed cycle, the first open cycle, the last open cycle and one past it, and expects `fault_rst` to react on the very next cycle. An unlock bit that fails to clear, or a kick pulse that lingers, is visible within two cycles through a control readback. A length register that is sampled live, rather than at the start of a closed phase, turns an accepted kick into a fault during the run that follows the reprogramming.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  // byte offsets of the host-visible registers
  localparam int OFS_UNLOCK = 'h00;
  localparam int OFS_CTRL   = 'h04;
  localparam int OFS_AUX    = 'h08;
  localparam int OFS_CLOSED = 'h0C;
  localparam int OFS_OPEN   = 'h10;

  // control register fields
  localparam int BIT_EN   = 0;
  localparam int BIT_KICK = 8;
  localparam int BIT_VIOL = 16;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_TRIP   = 2'd3
  } wwd_phase_e;
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              viol_i,
  output logic              en_o,
  output logic              kick_o,
  output logic [CNT_W-1:0]  closed_len_o,
  output logic [CNT_W-1:0]  open_len_o
);
  localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFS_UNLOCK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLOSED = ADDR_W'(OFS_CLOSED);
  localparam logic [ADDR_W-1:0] A_OPEN   = ADDR_W'(OFS_OPEN);

  logic              unlock_q;
  logic              en_q;
  logic              kick_q;
  logic [CNT_W-1:0]  closed_q;
  logic [CNT_W-1:0]  open_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  logic wr_unlock, wr_ctrl, wr_closed, wr_open, ctrl_take;

  assign wr_unlock = bus_wr && (bus_addr == A_UNLOCK);
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_closed = bus_wr && (bus_addr == A_CLOSED);
  assign wr_open   = bus_wr && (bus_addr == A_OPEN);
  assign ctrl_take = wr_ctrl && unlock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
      en_q     <= 1'b0;
      kick_q   <= 1'b0;
      closed_q <= '0;
      open_q   <= '0;
    end else begin
      kick_q <= 1'b0;
      if (wr_unlock)
        unlock_q <= bus_wdata[0];
      else if (wr_ctrl)
        unlock_q <= 1'b0;
      if (ctrl_take) begin
        en_q   <= bus_wdata[BIT_EN];
        // a kick counts only while already running and staying enabled
        kick_q <= bus_wdata[BIT_KICK] && bus_wdata[BIT_EN] && en_q;
      end
      if (wr_closed) closed_q <= bus_wdata[CNT_W-1:0];
      if (wr_open)   open_q   <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_UNLOCK: rd_mux[0] = unlock_q;
      A_CTRL: begin
        rd_mux[BIT_EN]   = en_q;
        rd_mux[BIT_KICK] = kick_q;
        rd_mux[BIT_VIOL] = viol_i;
      end
      A_CLOSED: rd_mux = DATA_W'(closed_q);
      A_OPEN:   rd_mux = DATA_W'(open_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata    = rdata_q;
  assign en_o         = en_q;
  assign kick_o       = kick_q;
  assign closed_len_o = closed_q;
  assign open_len_o   = open_q;
endmodule

// File: rtl/wwd_phase_ctr.sv
module wwd_phase_ctr
  import wwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] closed_len_i,
  input  logic [CNT_W-1:0] open_len_i,
  output logic             fault_o
);
  wwd_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] open_snap_q, open_snap_d;
  logic             fault_q, trip;
  logic             last;

  // a loaded value of 0 or 1 both mean a single-cycle phase
  assign last = (cnt_q <= CNT_W'(1));

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    open_snap_d = open_snap_q;
    trip        = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (en_i) begin
          phase_d     = PH_CLOSED;
          cnt_d       = closed_len_i;
          open_snap_d = open_len_i;
        end
      end
      PH_CLOSED: begin
        if (!en_i) begin
          phase_d = PH_IDLE;
        end else if (kick_i) begin
          phase_d = PH_TRIP;
          trip    = 1'b1;
        end else if (last) begin
          phase_d = PH_OPEN;
          cnt_d   = open_snap_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_OPEN: begin
        if (!en_i) begin
          phase_d = PH_IDLE;
        end else if (kick_i) begin
          phase_d     = PH_CLOSED;
          cnt_d       = closed_len_i;
          open_snap_d = open_len_i;
        end else if (last) begin
          phase_d = PH_TRIP;
          trip    = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_TRIP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      open_snap_q <= '0;
      fault_q     <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      cnt_q       <= cnt_d;
      open_snap_q <= open_snap_d;
      if (trip) fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fault_rst
);
  logic             en_w, kick_w, fault_w;
  logic [CNT_W-1:0] closed_w, open_w;

  wwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .viol_i(fault_w), .en_o(en_w), .kick_o(kick_w),
    .closed_len_o(closed_w), .open_len_o(open_w)
  );

  wwd_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst),
    .en_i(en_w), .kick_i(kick_w),
    .closed_len_i(closed_w), .open_len_i(open_w),
    .fault_o(fault_w)
  );

  assign fault_rst = fault_w;
endmodule

// File: rtl/wwd_checkers.sv
module wwd_regs_chk
  import wwd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              unlock,
  input logic              en,
  input logic              kick
);
  assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && !unlock) |=> ($stable(en) && !kick));

  assert_unlock_oneshot_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL)) |=> !unlock);

  assert_kick_single_R5: assert property (@(posedge clk) disable iff (rst)
    kick |=> !kick);

  assert_kick_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    kick |-> $past(en));
endmodule

module wwd_ctr_chk
  import wwd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       kick,
  input wwd_phase_e phase,
  input logic       fault
);
  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  assert_early_kick_R6: assert property (@(posedge clk) disable iff (rst)
    (kick && phase == PH_CLOSED) |=> fault);

  assert_open_kick_R5: assert property (@(posedge clk) disable iff (rst)
    (kick && phase == PH_OPEN && !fault) |=> (phase == PH_CLOSED && !fault));

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!en && phase != PH_TRIP) |=> (phase == PH_IDLE && !$rose(fault)));
endmodule

bind wwd_regs wwd_regs_chk #(.ADDR_W(ADDR_W)) u_regs_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .unlock(unlock_q), .en(en_q), .kick(kick_q)
);

bind wwd_phase_ctr wwd_ctr_chk u_ctr_chk (
  .clk(clk), .rst(rst), .en(en_i), .kick(kick_i),
  .phase(phase_q), .fault(fault_q)
);

// File: tb/window_watchdog_test.sv
module window_watchdog_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fault_rst;

  int errors = 0;
  int checks = 0;

  localparam logic [4:0] A_UNL = 5'h00, A_CTL = 5'h04, A_AUX = 5'h08,
                         A_CLS = 5'h0C, A_OPN = 5'h10;

  // vector table: closed length, open length, kick offset d, expected fault
  localparam int NV = 10;
  localparam int V_C[NV] = '{4, 4, 4, 4, 4, 1, 3, 3, 0, 6};
  localparam int V_O[NV] = '{4, 4, 4, 4, 4, 3, 1, 1, 2, 10};
  localparam int V_D[NV] = '{2, 4, 5, 8, 9, 2, 4, 5, 2, 12};
  localparam int V_F[NV] = '{1, 1, 0, 0, 1, 0, 0, 1, 0, 0};

  window_watchdog uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fault_rst(fault_rst)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts just after a falling edge and uses one rising edge
  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ctl(input logic [31:0] d);
    wr(A_UNL, 32'h1);
    wr(A_CTL, d);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    do_reset();

    // R1 reset state
    rd(A_CTL, r); check("R1 ctrl after reset", r, 32'h0);
    check("R1 fault after reset", {31'b0, fault_rst}, 32'h0);
    rd(A_CLS, r); check("R1 closed length after reset", r, 32'h0);

    // R2 register map
    wr(A_CLS, 32'hDEADBEEF); rd(A_CLS, r); check("R2 closed length readback", r, 32'hDEADBEEF);
    wr(A_OPN, 32'h12345678); rd(A_OPN, r); check("R2 open length readback", r, 32'h12345678);
    wr(A_AUX, 32'hFFFFFFFF); rd(A_AUX, r); check("R2 offset 0x08 reads zero", r, 32'h0);

    // R3 unlock gate
    wr(A_UNL, 32'h1); rd(A_UNL, r); check("R3 unlock reads set", r, 32'h1);
    wr(A_CTL, 32'h1); rd(A_UNL, r); check("R3 unlock cleared by ctrl write", r, 32'h0);
    rd(A_CTL, r); check("R3 unlocked enable taken", r, 32'h1);
    wr(A_CTL, 32'h0); rd(A_CTL, r); check("R3 locked write ignored", r, 32'h1);
    ctl(32'h0); rd(A_CTL, r); check("R3 unlocked disable taken", r, 32'h0);

    // R4 R5 R6 R7 window placement vectors
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_CLS, V_C[i]);
      wr(A_OPN, V_O[i]);
      ctl(32'h1);                        // enabling write at cycle E
      repeat (V_D[i] - 2) idle();
      ctl(32'h101);                      // kick write at cycle E+d
      idle();
      check($sformatf("R4 R5 R6 R7 vector %0d C=%0d O=%0d d=%0d", i, V_C[i], V_O[i], V_D[i]),
            {31'b0, fault_rst}, V_F[i]);
    end

    // R5 kick bit self-clears, accepted kick leaves no fault
    do_reset();
    wr(A_CLS, 32'd2); wr(A_OPN, 32'd50);
    ctl(32'h1);
    idle(); idle();
    ctl(32'h101);                        // d=4, open phase
    idle();
    rd(A_CTL, r); check("R5 kick bit cleared after kick", r, 32'h1);
    check("R5 no fault after open kick", {31'b0, fault_rst}, 32'h0);

    // R8 sticky fault
    do_reset();
    wr(A_CLS, 32'd5); wr(A_OPN, 32'd5);
    ctl(32'h1);
    ctl(32'h101);                        // d=2, closed phase
    idle();
    check("R6 early kick faults", {31'b0, fault_rst}, 32'h1);
    rd(A_CTL, r); check("R8 violation bit set", r, 32'h00010001);
    ctl(32'h0);
    repeat (5) idle();
    check("R8 fault survives disable", {31'b0, fault_rst}, 32'h1);
    rd(A_CTL, r); check("R8 violation bit after disable", r, 32'h00010000);
    do_reset();
    check("R8 fault cleared by reset", {31'b0, fault_rst}, 32'h0);
    rd(A_CTL, r); check("R8 ctrl clear after reset", r, 32'h0);

    // R10 disable returns to idle, kicks while disabled do nothing
    do_reset();
    wr(A_CLS, 32'd3); wr(A_OPN, 32'd3);
    ctl(32'h1);
    idle();
    ctl(32'h0);
    repeat (20) idle();
    check("R10 no fault after disable", {31'b0, fault_rst}, 32'h0);
    ctl(32'h100);
    idle();
    rd(A_CTL, r); check("R10 kick while disabled ignored", r, 32'h0);
    ctl(32'h101);
    rd(A_CTL, r); check("R10 enabling write is not a kick", r, 32'h1);
    idle(); idle();
    check("R10 no fault after combined start", {31'b0, fault_rst}, 32'h0);

    // R9 lengths captured at closed-phase start
    do_reset();
    wr(A_CLS, 32'd4); wr(A_OPN, 32'd4);
    ctl(32'h1);                          // E
    wr(A_CLS, 32'd10);                   // E+1
    wr(A_OPN, 32'd10);                   // E+2
    idle(); idle();
    ctl(32'h101);                        // K=E+6, open under old lengths
    idle();
    check("R9 old lengths used in running sequence", {31'b0, fault_rst}, 32'h0);
    repeat (3) idle();
    ctl(32'h101);                        // K+6, closed under new length 10
    idle();
    check("R9 new lengths used after restart", {31'b0, fault_rst}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule